// File: doc/BRIEF.md
# Four-Channel Compare Timer with Pulse-Width Outputs

This block is a register-mapped timer with four independent 16-bit channels. Each channel has its own clock divider, an up counter, four compare registers and one output pin. A shared run register starts and halts the channels one bit each. A channel can clear its counter when the count equals a chosen compare register. This gives a programmable period.

The pin of each channel starts from a programmable initial level. A compare match on the first compare register applies a configurable action to the pin: no change, force low, force high or toggle. In pulse-width mode the pin also returns to its initial level each time the counter clears, so that one compare register sets the duty point and another sets the period. If the action is "no change", the pin holds a fixed level, which gives 0% or 100% duty without any counting.

A simple synchronous bus gives 16-bit register access. Each channel also keeps sticky match flags that software clears by writing zeros.

Top module: `timer_pulse_unit`

## Requirements
- R1: The run register sits at byte address 0x00. Bit n set runs channel n and bit n clear halts it. A halted channel's counter keeps its value, and one channel's run bit has no effect on another channel.
- R2: Channel n's registers start at 0x10 + 0x40*n. The offsets are: control +0x00, mode +0x04, pin control +0x08, interrupt-enable storage +0x0C, status +0x10, counter +0x14, and compare registers A, B, C and D at +0x18, +0x1C, +0x20 and +0x24. Each register reads back what was written (status excepted, see R10). After reset every register reads 0, except the compare registers, which read 0xFFFF.
- R3: Control bits [1:0] hold a divider code p. A running channel's counter advances once every 4^p clock cycles. The first advance happens on the 4^p-th rising edge after the run bit is captured.
- R4: Control bits [7:5] select what clears the counter: 0 none, 1 compare A, 2 B, 5 C, 6 D, and any other code none. When the counter equals the selected register on an advance, it becomes 0 instead of incrementing.
- R5: A write to the counter register loads it directly, and this takes priority over counting.
- R6: A write to the pin control register drives the pin to the new bit 2 (the initial level) on the next edge, whether or not the channel is running.
- R7: Pin-control bits [1:0] give the action taken when the counter equals compare A on an advance: 0 no change, 1 low, 2 high, 3 toggle.
- R8: With mode bits [2:0] = 2 (pulse-width mode), the pin returns to its initial level whenever the counter clears. This takes precedence over an A action on the same advance. Mode bits [6:4] are stored only.
- R9: While a channel is halted, its pin keeps its present level.
- R10: Status bits [3:0] set when the counter equals compare A, B, C or D on an advance, and stay set. A status write clears each flag whose data bit is 0. A flag set in the same cycle as a clearing write stays set.
- R11: Read data is registered. It is valid on bus_rdata in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pwm_out | output | 4 | One output pin per channel |

## Verification
Two collisions are provoked on purpose.

The first is a clearing status write in the same cycle as a compare match. The bench loads the counter with the value of compare A, then issues a run write and a status write on consecutive edges, so the match and the clear land on the same edge. It then reads the status and expects the A flag still set.

The second is the period clear and the A action on the same advance, set up with equal A and B in pulse-width mode. The bench counts high cycles over whole periods and expects the pin to stay at the initial level.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

    localparam int NUM_CH     = 4;
    localparam int DW         = 16;
    localparam int AW         = 8;
    localparam int OFS_W      = 6;
    localparam int PSC_CODE_W = 2;
    localparam int PSC_W      = 2 * ((1 << PSC_CODE_W) - 1);
    localparam int NUM_GR     = 4;
    localparam int CH_IDX_W   = $clog2(NUM_CH);

    localparam logic [AW-1:0] RUN_ADDR  = 8'h00;
    localparam logic [AW-1:0] CH_BASE   = 8'h10;

    localparam logic [OFS_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [OFS_W-1:0] OFS_MODE = 6'h04;
    localparam logic [OFS_W-1:0] OFS_PIN  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_IEN  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h10;
    localparam logic [OFS_W-1:0] OFS_CNT  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_GR0  = 6'h18;

    typedef enum logic [2:0] {
        CLR_NONE = 3'd0,
        CLR_A    = 3'd1,
        CLR_B    = 3'd2,
        CLR_C    = 3'd5,
        CLR_D    = 3'd6
    } clr_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_PWM    = 3'd2
    } ch_mode_e;

    typedef struct packed {
        logic           init_lvl;
        pin_act_e       act;
    } pin_cfg_t;

    typedef struct packed {
        logic              hit;
        logic              wr;
        logic [OFS_W-1:0]  ofs;
    } ch_access_t;

    // mask of prescaler bits that must all be one for a tick: 4^p - 1
    function automatic logic [PSC_W-1:0] psc_mask(input logic [PSC_CODE_W-1:0] p);
        logic [PSC_W:0] one;
        one = (PSC_W+1)'(1) << (2 * p);
        return PSC_W'(one - (PSC_W+1)'(1));
    endfunction

    // offset of compare register i
    function automatic logic [OFS_W-1:0] gr_ofs(input int i);
        return OFS_GR0 + OFS_W'(4 * i);
    endfunction

endpackage

// File: rtl/tpu_bus_decode.sv
module tpu_bus_decode
    import tpu_pkg::*;
(
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    output logic                run_hit,
    output logic [CH_IDX_W-1:0] ch_idx,
    output ch_access_t          ch_acc [NUM_CH]
);
    logic [AW-1:0] rel;
    logic [AW-1:0] idx_full;
    logic          in_ch;

    always_comb begin
        rel      = bus_addr - CH_BASE;
        in_ch    = (bus_addr >= CH_BASE);
        idx_full = rel >> OFS_W;
        ch_idx   = idx_full[CH_IDX_W-1:0];
        run_hit  = bus_sel && (bus_addr == RUN_ADDR);
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_acc
        always_comb begin
            ch_acc[n].hit = bus_sel && in_ch && (idx_full == AW'(n));
            ch_acc[n].wr  = bus_wr;
            ch_acc[n].ofs = rel[OFS_W-1:0];
        end
    end

endmodule

// File: rtl/tpu_prescaler.sv
module tpu_prescaler
    import tpu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [PSC_CODE_W-1:0] code,
    output logic                  tick
);
    logic [PSC_W-1:0] phase;
    logic [PSC_W-1:0] mask;

    assign mask = psc_mask(code);
    assign tick = run && ((phase & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else
            phase <= phase + PSC_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && code != '0 && $stable(code)) |=> !tick); // R3

endmodule

// File: rtl/tpu_pin_ctl.sv
module tpu_pin_ctl
    import tpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr,
    input  logic     new_init,
    input  pin_cfg_t cfg,
    input  logic     match_a,
    input  logic     pwm_mode,
    input  logic     period_clr,
    output logic     pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (cfg_wr) begin
            pin <= new_init;
        end else if (pwm_mode && period_clr) begin
            pin <= cfg.init_lvl;
        end else if (match_a) begin
            case (cfg.act)
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                ACT_TOGGLE: pin <= !pin;
                default:    pin <= pin;
            endcase
        end
    end

    AST_PIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (pin == $past(new_init))); // R6
    AST_PWM_RETURN: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && period_clr && !cfg_wr) |=> (pin == $past(cfg.init_lvl))); // R8

endmodule

// File: rtl/tpu_channel.sv
module tpu_channel
    import tpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  ch_access_t    acc,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic          pin
);
    logic [DW-1:0] ctrl_q, mode_q, pinc_q, ien_q, cnt_q;
    logic [DW-1:0] gr_q [NUM_GR];
    logic [NUM_GR-1:0] flag_q, match;
    logic tick, clr_hit;
    logic wr_any, wr_ctrl, wr_mode, wr_pin, wr_ien, wr_stat, wr_cnt;
    pin_cfg_t pcfg;

    assign wr_any  = acc.hit && acc.wr;
    assign wr_ctrl = wr_any && acc.ofs == OFS_CTRL;
    assign wr_mode = wr_any && acc.ofs == OFS_MODE;
    assign wr_pin  = wr_any && acc.ofs == OFS_PIN;
    assign wr_ien  = wr_any && acc.ofs == OFS_IEN;
    assign wr_stat = wr_any && acc.ofs == OFS_STAT;
    assign wr_cnt  = wr_any && acc.ofs == OFS_CNT;

    tpu_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .code (ctrl_q[PSC_CODE_W-1:0]),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            pinc_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_mode) mode_q <= wdata;
            if (wr_pin)  pinc_q <= wdata;
            if (wr_ien)  ien_q  <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
        always_ff @(posedge clk) begin
            if (rst)
                gr_q[i] <= '1;
            else if (wr_any && acc.ofs == gr_ofs(i))
                gr_q[i] <= wdata;
        end
        assign match[i] = tick && (cnt_q == gr_q[i]);
    end

    always_comb begin
        case (clr_sel_e'(ctrl_q[7:5]))
            CLR_A:   clr_hit = match[0];
            CLR_B:   clr_hit = match[1];
            CLR_C:   clr_hit = match[2];
            CLR_D:   clr_hit = match[3];
            default: clr_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wdata;
        else if (tick)
            cnt_q <= clr_hit ? '0 : cnt_q + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else if (wr_stat)
            flag_q <= (flag_q & wdata[NUM_GR-1:0]) | match;
        else
            flag_q <= flag_q | match;
    end

    assign pcfg.init_lvl = pinc_q[2];
    assign pcfg.act      = pin_act_e'(pinc_q[1:0]);

    tpu_pin_ctl u_pin (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (wr_pin),
        .new_init   (wdata[2]),
        .cfg        (pcfg),
        .match_a    (match[0]),
        .pwm_mode   (ch_mode_e'(mode_q[2:0]) == MODE_PWM),
        .period_clr (clr_hit),
        .pin        (pin)
    );

    always_comb begin
        rd_val = '0;
        case (acc.ofs)
            OFS_CTRL: rd_val = ctrl_q;
            OFS_MODE: rd_val = mode_q;
            OFS_PIN:  rd_val = pinc_q;
            OFS_IEN:  rd_val = ien_q;
            OFS_STAT: rd_val = DW'(flag_q);
            OFS_CNT:  rd_val = cnt_q;
            default: begin
                for (int i = 0; i < NUM_GR; i++)
                    if (acc.ofs == gr_ofs(i)) rd_val = gr_q[i];
            end
        endcase
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt_q)); // R1
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_hit && !wr_cnt) |=> (cnt_q == '0)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(wdata))); // R5
    AST_PIN_HALTED: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_pin) |=> $stable(pin)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|match) |=> ((flag_q & $past(match)) == $past(match))); // R10

endmodule

// File: rtl/timer_pulse_unit.sv
module timer_pulse_unit
    import tpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic [3:0]    pwm_out
);
    logic                run_hit;
    logic [CH_IDX_W-1:0] ch_idx;
    ch_access_t          ch_acc [NUM_CH];
    logic [DW-1:0]       ch_rd [NUM_CH];
    logic [NUM_CH-1:0]   run_q;
    logic [NUM_CH-1:0]   ch_hit_vec;
    logic                rd_req;

    tpu_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .run_hit  (run_hit),
        .ch_idx   (ch_idx),
        .ch_acc   (ch_acc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (run_hit && bus_wr)
            run_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_hit_vec[n] = ch_acc[n].hit;
        tpu_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run_q[n]),
            .acc    (ch_acc[n]),
            .wdata  (bus_wdata),
            .rd_val (ch_rd[n]),
            .pin    (pwm_out[n])
        );
    end

    assign rd_req = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_req) begin
            if (run_hit)
                bus_rdata <= DW'(run_q);
            else if (|ch_hit_vec)
                bus_rdata <= ch_rd[ch_idx];
            else
                bus_rdata <= '0;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(bus_rdata)); // R11
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_hit_vec)); // R2

endmodule

// File: tb/sim_timer_pulse_unit.sv
module sim_timer_pulse_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_sel = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    timer_pulse_unit u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    localparam logic [7:0] O_CTRL = 8'h00, O_MODE = 8'h04, O_PIN = 8'h08,
        O_IEN = 8'h0C, O_STAT = 8'h10, O_CNT = 8'h14, O_A = 8'h18,
        O_B = 8'h1C, O_C = 8'h20, O_D = 8'h24;

    function automatic logic [7:0] ra(input int ch, input logic [7:0] ofs);
        return 8'h10 + 8'(ch * 8'h40) + ofs;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    // run channel for n cycles from counter 0 and read counter back
    task automatic run_count(input int ch, input logic [15:0] ctrl, input int n,
                             output logic [15:0] v);
        wr(8'h00, 16'h0);
        wr(ra(ch, O_CTRL), ctrl);
        wr(ra(ch, O_CNT), 16'h0);
        wr(8'h00, 16'(1 << ch));
        repeat (n - 1) @(negedge clk);
        wr(8'h00, 16'h0);
        rd(ra(ch, O_CNT), v);
    endtask

    function automatic int exp_high(input int init, input int act,
                                    input int a, input int b, input int p);
        int per = 1 << (2 * p);
        int lvl;
        if (act == 0 || a > b) return (init != 0) ? (b + 1) * per : 0;
        lvl = (act == 1) ? 0 : (act == 2) ? 1 : (init == 0 ? 1 : 0);
        return ((init != 0 ? a + 1 : 0) + (lvl != 0 ? b - a : 0)) * per;
    endfunction

    task automatic pwm_case(input int ch, input int p, input int init,
                            input int act, input int a, input int b);
        int hi = 0;
        int win = 2 * (b + 1) * (1 << (2 * p));
        wr(8'h00, 16'h0);
        wr(ra(ch, O_CTRL), 16'((2 << 5) | p));
        wr(ra(ch, O_MODE), 16'h2);
        wr(ra(ch, O_A), 16'(a));
        wr(ra(ch, O_B), 16'(b));
        wr(ra(ch, O_CNT), 16'h0);
        wr(ra(ch, O_PIN), 16'((init << 2) | act));
        wr(8'h00, 16'(1 << ch));
        repeat (win) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
        chk($sformatf("R8 R7 R3 pwm p=%0d init=%0d act=%0d A=%0d B=%0d", p, init, act, a, b),
            hi, 2 * exp_high(init, act, a, b, p));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int hi;
        int mism;
        logic held;
        int ab [5][2];
        ab = '{'{0, 3}, '{2, 5}, '{5, 5}, '{6, 3}, '{1, 7}};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        chk("R2 reset pins", int'(pwm_out), 0);
        rd(8'h00, v);            chk("R1 reset run reg", v, 0);
        rd(ra(2, O_CTRL), v);    chk("R2 reset ctrl", v, 0);
        rd(ra(2, O_A), v);       chk("R2 reset compare A", v, 16'hFFFF);
        rd(ra(3, O_D), v);       chk("R2 reset compare D", v, 16'hFFFF);
        rd(ra(1, O_CNT), v);     chk("R2 reset counter", v, 0);

        // register map readback
        wr(ra(1, O_MODE), 16'h0072); rd(ra(1, O_MODE), v); chk("R8 R2 mode store", v, 16'h0072);
        wr(ra(1, O_IEN), 16'h000F);  rd(ra(1, O_IEN), v);  chk("R2 ien store", v, 16'h000F);
        wr(ra(1, O_C), 16'h0ABC);    rd(ra(1, O_C), v);    chk("R2 compare C", v, 16'h0ABC);
        rd(ra(2, O_C), v);           chk("R2 other channel C", v, 16'hFFFF);
        wr(ra(1, O_MODE), 16'h0000);
        wr(ra(1, O_C), 16'hFFFF);

        // counter load and read timing
        wr(ra(2, O_CNT), 16'h1234);
        rd(ra(2, O_CNT), v); chk("R5 R11 counter load", v, 16'h1234);
        @(negedge clk);
        chk("R11 rdata holds", bus_rdata, 16'h1234);

        // clear source sweep on channel 2, n=10 advances at p=0
        wr(ra(2, O_A), 16'd6); wr(ra(2, O_B), 16'd2);
        wr(ra(2, O_C), 16'd4); wr(ra(2, O_D), 16'd3);
        run_count(2, 16'(0 << 5), 10, v); chk("R4 R1 clear none", v, 10);
        run_count(2, 16'(1 << 5), 10, v); chk("R4 clear on A", v, 10 % 7);
        run_count(2, 16'(2 << 5), 10, v); chk("R4 clear on B", v, 10 % 3);
        run_count(2, 16'(5 << 5), 10, v); chk("R4 clear on C", v, 10 % 5);
        run_count(2, 16'(6 << 5), 10, v); chk("R4 clear on D", v, 10 % 4);
        run_count(2, 16'(3 << 5), 10, v); chk("R4 reserved code", v, 10);
        wr(ra(2, O_D), 16'hFFFF); wr(ra(2, O_C), 16'hFFFF);
        wr(ra(2, O_A), 16'hFFFF); wr(ra(2, O_B), 16'hFFFF);
        run_count(2, 16'd1, 10, v); chk("R3 divide by 4", v, 10 / 4);
        run_count(2, 16'd2, 40, v); chk("R3 divide by 16", v, 40 / 16);
        run_count(2, 16'd3, 200, v); chk("R3 divide by 64", v, 200 / 64);
        rd(ra(2, O_CNT), v);
        repeat (5) @(negedge clk);
        rd(ra(2, O_CNT), v); chk("R1 halted counter holds", v, 200 / 64);

        // pulse-width sweep on channel 0
        for (int p = 0; p < 2; p++)
            for (int init = 0; init < 2; init++)
                for (int act = 0; act < 4; act++)
                    for (int k = 0; k < 5; k++)
                        pwm_case(0, p, init, act, ab[k][0], ab[k][1]);
        pwm_case(0, 2, 0, 2, 1, 3);
        pwm_case(0, 3, 1, 1, 0, 2);
        rd(ra(3, O_CNT), v); chk("R1 idle channel untouched", v, 0);

        // status flags after a run with A=2, B=5
        pwm_case(0, 0, 0, 2, 2, 5);
        wr(8'h00, 16'h0);
        rd(ra(0, O_STAT), v); chk("R10 flags A and B", v, 16'h0003);
        wr(ra(0, O_STAT), 16'hFFFE);
        rd(ra(0, O_STAT), v); chk("R10 write-zero clears A only", v, 16'h0002);

        // halted pin holds
        held = pwm_out[0];
        mism = 0;
        repeat (20) begin
            @(negedge clk);
            if (pwm_out[0] != held) mism++;
        end
        chk("R9 halted pin holds", mism, 0);

        // normal mode toggle, clear on A
        for (int p = 0; p < 2; p++) begin
            wr(8'h00, 16'h0);
            wr(ra(1, O_CTRL), 16'((1 << 5) | p));
            wr(ra(1, O_MODE), 16'h0);
            wr(ra(1, O_A), 16'd3);
            wr(ra(1, O_CNT), 16'h0);
            wr(ra(1, O_PIN), 16'h3);
            wr(8'h00, 16'h2);
            hi = 0;
            repeat (8 * (1 << (2 * p))) begin
                @(negedge clk);
                if (pwm_out[1]) hi++;
            end
            chk($sformatf("R7 toggle normal p=%0d", p), hi, 4 * (1 << (2 * p)));
        end

        // match and clearing write on the same edge
        wr(8'h00, 16'h0);
        wr(ra(1, O_CTRL), 16'h0);
        wr(ra(1, O_A), 16'd100);
        wr(ra(1, O_CNT), 16'd100);
        wr(ra(1, O_STAT), 16'h0);
        wr(8'h00, 16'h2);
        wr(ra(1, O_STAT), 16'h0);
        wr(8'h00, 16'h0);
        rd(ra(1, O_STAT), v); chk("R10 set wins over clear", v, 16'h0001);
        wr(ra(1, O_STAT), 16'h0);
        rd(ra(1, O_STAT), v); chk("R10 cleared", v, 0);

        // pin control write applies at once
        wr(ra(3, O_PIN), 16'h4);
        chk("R6 halted init high", int'(pwm_out[3]), 1);
        wr(ra(3, O_PIN), 16'h0);
        chk("R6 halted init low", int'(pwm_out[3]), 0);
        wr(ra(3, O_CTRL), 16'h0);
        wr(8'h00, 16'h8);
        wr(ra(3, O_PIN), 16'h4);
        chk("R6 running init high", int'(pwm_out[3]), 1);
        wr(8'h00, 16'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule